// File: doc/BRIEF.md
# CAN Fault Confinement and Interrupt Unit

This unit sits beside a CAN protocol engine and keeps the node's transmit and receive error counts. From them it derives three fault-confinement states: warning, passive and bus-off. The engine supplies one-cycle pulses for transmit and receive errors and successes, and a cause vector that classifies each bus error. Mailbox logic supplies completion, abort and lost-message pulses. The unit latches the error causes, raises interrupt flags, and drives two interrupt lines.

Software reaches the unit through a single write port with four addresses. Address 0 is the status word: writing ones to its cause bits clears them. Address 1 is the flag word, which is also write-one-to-clear. Address 2 is the line and flag enable mask. Address 3 is the per-mailbox line selection. The status and flag words are always visible on output ports, and so are both counters. Once a node is bus-off it stays there until software pulses the re-initialise input.

Top module: `can_fault_irq_unit`

## Requirements
- R1: Counter arithmetic:
  - A transmit error adds 8 to the transmit count. A transmit success subtracts 1, but never below 0.
  - A receive error adds 1 to the receive count, holding at 255. A receive success subtracts 1, but never below 0.
  - When an error and a success for the same counter arrive in one cycle, the error is applied.
- R2: Status bit 16 (warning) is 1 exactly when either count is 96 or more.
- R3: Status bit 17 (passive) is 1 exactly when either count is 128 or more.
- R4: Bus-off behaviour:
  - Status bit 18 and `busOff` are 1 exactly when the transmit count exceeds 255.
  - While bus-off, every counter event is ignored.
  - A `reinitReq` pulse sets both counts to 0, which ends bus-off.
- R5: Bus-error causes:
  - `busErrCause[i]` sets status bit 19+i. The bit meanings are: 0 ack, 1 stuff, 2 CRC, 3 stuck-dominant, 4 bit, 5 form.
  - A write to address 0 clears each cause bit whose data bit is 1. A set in the same cycle wins over the clear.
  - Writes to address 0 have no effect on the other status bits.
- R6: Flag bits 8 (warning), 9 (passive) and 10 (bus-off) are set one cycle after the matching state is entered. They are not set again while the node stays in that state.
- R7: Event flags:
  - `rxLostEvt` sets flag bit 11.
  - `abortAckEvt` sets flag bit 14.
  - `mbxDoneEvt` sets flag bit 15 and loads `mbxNum` into flag bits 4:0.
- R8: A write to address 1 clears each of flag bits 8, 9, 10, 11, 14 and 15 whose data bit is 1. A set in the same cycle wins over the clear. Bits 4:0 are not changed by the write.
- R9: Line gating and steering:
  - Mask bits 8, 9, 10, 11, 14 and 15, loaded by a write to address 2, enable the flags at the same positions.
  - Mask bit 0 enables line 0 and mask bit 1 enables line 1.
  - Mask bit 2 sends the enabled system flags (8, 9, 10, 11, 14) to line 1 instead of line 0.
  - Each line falls once its enabled flags are cleared.
- R10: Bit n of the level register (address 3) routes the mailbox flag to line 1 when the reported mailbox is n, and to line 0 when that bit is 0.
- R11: After reset, all outputs are 0: both counts, the status and flag words, both lines and `busOff`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txErrEvt | input | 1 | Transmit error pulse |
| txOkEvt | input | 1 | Transmit success pulse |
| rxErrEvt | input | 1 | Receive error pulse |
| rxOkEvt | input | 1 | Receive success pulse |
| busErrCause | input | 6 | Bus error cause pulses (ack, stuff, CRC, stuck, bit, form) |
| rxLostEvt | input | 1 | Receive message lost pulse |
| abortAckEvt | input | 1 | Transmit abort acknowledged pulse |
| mbxDoneEvt | input | 1 | Mailbox completion pulse |
| mbxNum | input | MBX_W | Number of the completing mailbox |
| reinitReq | input | 1 | Software re-initialise pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 status, 1 flags, 2 mask, 3 level) |
| regWData | input | 32 | Register write data |
| statusWord | output | 32 | States and latched error causes |
| flagWord | output | 32 | Interrupt flags and last mailbox number |
| txErrCnt | output | TEC_W | Transmit error count |
| rxErrCnt | output | REC_W | Receive error count |
| irqLine0 | output | 1 | Interrupt line 0 |
| irqLine1 | output | 1 | Interrupt line 1 |
| busOff | output | 1 | Bus-off indication |

## Verification
A wrong counter value shows up on the count ports at the very next sample. It reaches the state bits once a threshold is crossed, and reaches the flags one cycle later. A stale entry-tracking register would show as a missing or repeated state flag one cycle after a crossing, or after a clear followed by further errors. A wrong mask or level bit shows only when a flag it governs is pending, so the stimulus holds flags pending under each mask setting. The per-cycle reference comparison catches any such divergence in the cycle it first appears.

// File: rtl/can_fault_pkg.sv
package can_fault_pkg;

  localparam int CAUSE_N   = 6;
  localparam int FLAG_N    = 6;
  localparam int ST_WARN   = 16;
  localparam int ST_PASS   = 17;
  localparam int ST_OFF    = 18;
  localparam int ST_CAUSE0 = 19;

  // flag order: warning, passive, bus-off, lost, abort, mailbox
  localparam int FLAG_POS [FLAG_N] = '{8, 9, 10, 11, 14, 15};

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_FLAG   = 2'd1;
  localparam logic [1:0] ADDR_MASK   = 2'd2;
  localparam logic [1:0] ADDR_LEVEL  = 2'd3;

  typedef struct packed {
    logic               txUp;
    logic               txDown;
    logic               rxUp;
    logic               rxDown;
    logic               cntClear;
    logic [CAUSE_N-1:0] causeSet;
    logic [FLAG_N-1:0]  flagSet;
    logic               statusWr;
    logic               flagWr;
    logic               maskWr;
    logic               levelWr;
  } strobeT;

endpackage

// File: rtl/can_fault_ctrl.sv
module can_fault_ctrl
  import can_fault_pkg::*;
#(
  parameter int TEC_W    = 9,
  parameter int REC_W    = 8,
  parameter int WARN_LVL = 96,
  parameter int PASS_LVL = 128,
  parameter int OFF_LVL  = 255
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txErrEvt,
  input  logic                txOkEvt,
  input  logic                rxErrEvt,
  input  logic                rxOkEvt,
  input  logic [CAUSE_N-1:0]  busErrCause,
  input  logic                rxLostEvt,
  input  logic                abortAckEvt,
  input  logic                mbxDoneEvt,
  input  logic                reinitReq,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [TEC_W-1:0]    tecQ,
  input  logic [REC_W-1:0]    recQ,
  output strobeT              stb,
  output logic                stWarn,
  output logic                stPass,
  output logic                stOff
);

  localparam logic [TEC_W-1:0] TEC_WARN = TEC_W'(WARN_LVL);
  localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASS_LVL);
  localparam logic [TEC_W-1:0] TEC_OFF  = TEC_W'(OFF_LVL);
  localparam logic [REC_W-1:0] REC_WARN = REC_W'(WARN_LVL);
  localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASS_LVL);

  logic warnPrev, passPrev, offPrev;
  logic live;

  assign stOff  = tecQ > TEC_OFF;
  assign stPass = (tecQ >= TEC_PASS) || (recQ >= REC_PASS);
  assign stWarn = (tecQ >= TEC_WARN) || (recQ >= REC_WARN);
  assign live   = !stOff && !reinitReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warnPrev <= 1'b0;
      passPrev <= 1'b0;
      offPrev  <= 1'b0;
    end else begin
      warnPrev <= stWarn;
      passPrev <= stPass;
      offPrev  <= stOff;
    end
  end

  always_comb begin
    stb          = '0;
    stb.txUp     = live && txErrEvt;
    stb.txDown   = live && txOkEvt && !txErrEvt;
    stb.rxUp     = live && rxErrEvt;
    stb.rxDown   = live && rxOkEvt && !rxErrEvt;
    stb.cntClear = reinitReq;
    stb.causeSet = busErrCause;
    stb.flagSet  = {mbxDoneEvt, abortAckEvt, rxLostEvt,
                    stOff && !offPrev, stPass && !passPrev, stWarn && !warnPrev};
    stb.statusWr = regWrEn && (regAddr == ADDR_STATUS);
    stb.flagWr   = regWrEn && (regAddr == ADDR_FLAG);
    stb.maskWr   = regWrEn && (regAddr == ADDR_MASK);
    stb.levelWr  = regWrEn && (regAddr == ADDR_LEVEL);
  end

endmodule

// File: rtl/can_fault_dp.sv
module can_fault_dp
  import can_fault_pkg::*;
#(
  parameter int TEC_W   = 9,
  parameter int REC_W   = 8,
  parameter int NUM_MBX = 32,
  parameter int MBX_W   = 5,
  parameter int TX_STEP = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [31:0]       wData,
  input  logic [MBX_W-1:0]  mbxNum,
  input  logic              stWarn,
  input  logic              stPass,
  input  logic              stOff,
  output logic [TEC_W-1:0]  tecQ,
  output logic [REC_W-1:0]  recQ,
  output logic [31:0]       statusWord,
  output logic [31:0]       flagWord,
  output logic              irqLine0,
  output logic              irqLine1
);

  localparam logic [TEC_W-1:0] TX_INC  = TEC_W'(TX_STEP);
  localparam logic [REC_W-1:0] REC_MAX = '1;

  logic [CAUSE_N-1:0] causeQ;
  logic [FLAG_N-1:0]  flagQ;
  logic [FLAG_N-1:0]  flagEnQ;
  logic [2:0]         lineEnQ;
  logic [MBX_W-1:0]   numQ;
  logic [NUM_MBX-1:0] levelQ;
  logic               sysPend, mbxPend, mbxLvl;

  // error counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tecQ <= '0;
      recQ <= '0;
    end else if (stb.cntClear) begin
      tecQ <= '0;
      recQ <= '0;
    end else begin
      if (stb.txUp)                       tecQ <= tecQ + TX_INC;
      else if (stb.txDown && tecQ != '0)  tecQ <= tecQ - 1'b1;
      if (stb.rxUp && recQ != REC_MAX)    recQ <= recQ + 1'b1;
      else if (stb.rxDown && recQ != '0)  recQ <= recQ - 1'b1;
    end
  end

  // latched bus-error causes, write-one-to-clear, set wins
  for (genvar i = 0; i < CAUSE_N; i++) begin : g_cause
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) causeQ[i] <= 1'b0;
      else       causeQ[i] <= stb.causeSet[i] |
                              (causeQ[i] & ~(stb.statusWr & wData[ST_CAUSE0+i]));
    end
  end

  // interrupt flags and their enables
  for (genvar k = 0; k < FLAG_N; k++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ[k]   <= 1'b0;
        flagEnQ[k] <= 1'b0;
      end else begin
        flagQ[k] <= stb.flagSet[k] | (flagQ[k] & ~(stb.flagWr & wData[FLAG_POS[k]]));
        if (stb.maskWr) flagEnQ[k] <= wData[FLAG_POS[k]];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineEnQ <= '0;
      numQ    <= '0;
      levelQ  <= '0;
    end else begin
      if (stb.maskWr)           lineEnQ <= wData[2:0];
      if (stb.flagSet[FLAG_N-1]) numQ   <= mbxNum;
      if (stb.levelWr)          levelQ  <= wData[NUM_MBX-1:0];
    end
  end

  always_comb begin
    statusWord          = '0;
    statusWord[ST_WARN] = stWarn;
    statusWord[ST_PASS] = stPass;
    statusWord[ST_OFF]  = stOff;
    statusWord[ST_CAUSE0 +: CAUSE_N] = causeQ;
    flagWord            = '0;
    for (int k = 0; k < FLAG_N; k++) flagWord[FLAG_POS[k]] = flagQ[k];
    flagWord[MBX_W-1:0] = numQ;
  end

  assign sysPend  = |(flagQ[FLAG_N-2:0] & flagEnQ[FLAG_N-2:0]);
  assign mbxPend  = flagQ[FLAG_N-1] & flagEnQ[FLAG_N-1];
  assign mbxLvl   = levelQ[numQ];
  assign irqLine0 = lineEnQ[0] & ((sysPend & ~lineEnQ[2]) | (mbxPend & ~mbxLvl));
  assign irqLine1 = lineEnQ[1] & ((sysPend &  lineEnQ[2]) | (mbxPend &  mbxLvl));

endmodule

// File: rtl/can_fault_irq_unit.sv
module can_fault_irq_unit
  import can_fault_pkg::*;
#(
  parameter int TEC_W    = 9,
  parameter int REC_W    = 8,
  parameter int NUM_MBX  = 32,
  parameter int WARN_LVL = 96,
  parameter int PASS_LVL = 128,
  parameter int OFF_LVL  = 255,
  parameter int TX_STEP  = 8,
  localparam int MBX_W   = $clog2(NUM_MBX)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txErrEvt,
  input  logic              txOkEvt,
  input  logic              rxErrEvt,
  input  logic              rxOkEvt,
  input  logic [5:0]        busErrCause,
  input  logic              rxLostEvt,
  input  logic              abortAckEvt,
  input  logic              mbxDoneEvt,
  input  logic [MBX_W-1:0]  mbxNum,
  input  logic              reinitReq,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWData,
  output logic [31:0]       statusWord,
  output logic [31:0]       flagWord,
  output logic [TEC_W-1:0]  txErrCnt,
  output logic [REC_W-1:0]  rxErrCnt,
  output logic              irqLine0,
  output logic              irqLine1,
  output logic              busOff
);

  strobeT stb;
  logic   stWarn, stPass, stOff;

  can_fault_ctrl #(
    .TEC_W(TEC_W), .REC_W(REC_W),
    .WARN_LVL(WARN_LVL), .PASS_LVL(PASS_LVL), .OFF_LVL(OFF_LVL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .txErrEvt(txErrEvt), .txOkEvt(txOkEvt), .rxErrEvt(rxErrEvt), .rxOkEvt(rxOkEvt),
    .busErrCause(busErrCause), .rxLostEvt(rxLostEvt), .abortAckEvt(abortAckEvt),
    .mbxDoneEvt(mbxDoneEvt), .reinitReq(reinitReq),
    .regWrEn(regWrEn), .regAddr(regAddr),
    .tecQ(txErrCnt), .recQ(rxErrCnt),
    .stb(stb), .stWarn(stWarn), .stPass(stPass), .stOff(stOff)
  );

  can_fault_dp #(
    .TEC_W(TEC_W), .REC_W(REC_W), .NUM_MBX(NUM_MBX), .MBX_W(MBX_W), .TX_STEP(TX_STEP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wData(regWData), .mbxNum(mbxNum),
    .stWarn(stWarn), .stPass(stPass), .stOff(stOff),
    .tecQ(txErrCnt), .recQ(rxErrCnt),
    .statusWord(statusWord), .flagWord(flagWord),
    .irqLine0(irqLine0), .irqLine1(irqLine1)
  );

  assign busOff = stOff;

endmodule

// File: rtl/can_fault_chk.sv
module can_fault_chk #(
  parameter int TEC_W   = 9,
  parameter int REC_W   = 8,
  parameter int TX_STEP = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             txErrEvt,
  input logic             reinitReq,
  input logic [5:0]       busErrCause,
  input logic [5:0]       causeBits,
  input logic             warnBit,
  input logic             warnFlag,
  input logic [7:0]       sysFlags,
  input logic [TEC_W-1:0] txErrCnt,
  input logic [REC_W-1:0] rxErrCnt,
  input logic             irqLine0,
  input logic             irqLine1,
  input logic             busOff
);

  // R1: a counted transmit error adds the step
  a_r1_tx_step: assert property (@(posedge clk) disable iff (!rstN)
    (txErrEvt && !busOff && !reinitReq) |=> (txErrCnt == $past(txErrCnt) + TEC_W'(TX_STEP)));

  // R4: counters frozen while bus-off
  a_r4_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (busOff && !reinitReq) |=> ($stable(txErrCnt) && $stable(rxErrCnt)));

  // R4: bus-off ends only through re-initialisation
  a_r4_exit_by_init: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busOff) |-> $past(reinitReq));

  // R5: each cause pulse leaves its bit set
  for (genvar i = 0; i < 6; i++) begin : g_cause
    a_r5_cause_latch: assert property (@(posedge clk) disable iff (!rstN)
      busErrCause[i] |=> causeBits[i]);
  end

  // R6: warning flag rises only after the warning state was present
  a_r6_warn_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(warnFlag) |-> $past(warnBit));

  // R9: a line is high only while some flag is pending
  a_r9_line_source: assert property (@(posedge clk) disable iff (!rstN)
    (irqLine0 || irqLine1) |-> (|sysFlags));

endmodule

bind can_fault_irq_unit can_fault_chk #(
  .TEC_W(TEC_W), .REC_W(REC_W), .TX_STEP(TX_STEP)
) u_chk (
  .clk(clk), .rstN(rstN), .txErrEvt(txErrEvt), .reinitReq(reinitReq),
  .busErrCause(busErrCause), .causeBits(statusWord[24:19]),
  .warnBit(statusWord[16]), .warnFlag(flagWord[8]), .sysFlags(flagWord[15:8]),
  .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt),
  .irqLine0(irqLine0), .irqLine1(irqLine1), .busOff(busOff)
);

// File: tb/tb_can_fault_irq_unit.sv
module tb_can_fault_irq_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txErrEvt, txOkEvt, rxErrEvt, rxOkEvt;
  logic [5:0]  busErrCause;
  logic        rxLostEvt, abortAckEvt, mbxDoneEvt;
  logic [4:0]  mbxNum;
  logic        reinitReq, regWrEn;
  logic [1:0]  regAddr;
  logic [31:0] regWData;
  logic [31:0] statusWord, flagWord;
  logic [8:0]  txErrCnt;
  logic [7:0]  rxErrCnt;
  logic        irqLine0, irqLine1, busOff;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  can_fault_irq_unit dut (
    .clk(clk), .rstN(rstN),
    .txErrEvt(txErrEvt), .txOkEvt(txOkEvt), .rxErrEvt(rxErrEvt), .rxOkEvt(rxOkEvt),
    .busErrCause(busErrCause), .rxLostEvt(rxLostEvt), .abortAckEvt(abortAckEvt),
    .mbxDoneEvt(mbxDoneEvt), .mbxNum(mbxNum), .reinitReq(reinitReq),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWData(regWData),
    .statusWord(statusWord), .flagWord(flagWord),
    .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt),
    .irqLine0(irqLine0), .irqLine1(irqLine1), .busOff(busOff)
  );

  // ---------------- behavioural reference ----------------
  int          mTec, mRec, mNum;
  bit [5:0]    mCause;
  bit          fWarn, fPass, fOff, fLost, fAbort, fMbx;
  bit          pW, pP, pO;
  bit [2:0]    mLine;
  bit [5:0]    mEn;
  bit [31:0]   mLvl;

  function automatic bit inWarn(); return (mTec >= 96) || (mRec >= 96); endfunction
  function automatic bit inPass(); return (mTec >= 128) || (mRec >= 128); endfunction
  function automatic bit inOff();  return mTec > 255; endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTec = 0; mRec = 0; mNum = 0; mCause = '0;
      fWarn = 0; fPass = 0; fOff = 0; fLost = 0; fAbort = 0; fMbx = 0;
      pW = 0; pP = 0; pO = 0; mLine = '0; mEn = '0; mLvl = '0;
    end else begin
      bit cw, cp, co, wS, wF;
      cw = inWarn(); cp = inPass(); co = inOff();
      wS = regWrEn && regAddr == 2'd0;
      wF = regWrEn && regAddr == 2'd1;
      for (int i = 0; i < 6; i++)
        mCause[i] = busErrCause[i] | (mCause[i] & !(wS && regWData[19+i]));
      fWarn  = (cw && !pW)  | (fWarn  & !(wF && regWData[8]));
      fPass  = (cp && !pP)  | (fPass  & !(wF && regWData[9]));
      fOff   = (co && !pO)  | (fOff   & !(wF && regWData[10]));
      fLost  = rxLostEvt    | (fLost  & !(wF && regWData[11]));
      fAbort = abortAckEvt  | (fAbort & !(wF && regWData[14]));
      fMbx   = mbxDoneEvt   | (fMbx   & !(wF && regWData[15]));
      if (mbxDoneEvt) mNum = int'(mbxNum);
      if (regWrEn && regAddr == 2'd2) begin
        mLine = regWData[2:0];
        mEn   = {regWData[15], regWData[14], regWData[11], regWData[10], regWData[9], regWData[8]};
      end
      if (regWrEn && regAddr == 2'd3) mLvl = regWData;
      pW = cw; pP = cp; pO = co;
      if (reinitReq) begin
        mTec = 0; mRec = 0;
      end else if (!co) begin
        if (txErrEvt) mTec += 8;
        else if (txOkEvt && mTec > 0) mTec -= 1;
        if (rxErrEvt) begin
          if (mRec < 255) mRec += 1;
        end else if (rxOkEvt && mRec > 0) mRec -= 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit sys, mb, lv;
    sys = (fWarn & mEn[0]) | (fPass & mEn[1]) | (fOff & mEn[2]) | (fLost & mEn[3]) | (fAbort & mEn[4]);
    mb  = fMbx & mEn[5];
    lv  = mLvl[mNum];
    chk("R1 txErrCnt", 32'(txErrCnt), 32'(mTec));
    chk("R1 rxErrCnt", 32'(rxErrCnt), 32'(mRec));
    chk("R2 warning bit", 32'(statusWord[16]), 32'(inWarn()));
    chk("R3 passive bit", 32'(statusWord[17]), 32'(inPass()));
    chk("R4 bus-off bit", 32'(statusWord[18]), 32'(inOff()));
    chk("R4 busOff port", 32'(busOff), 32'(inOff()));
    chk("R5 cause bits", 32'(statusWord[24:19]), 32'(mCause));
    chk("R5 status other bits", {statusWord[31:25], statusWord[15:0]}, 32'd0);
    chk("R6 state flags", 32'(flagWord[10:8]), 32'({fOff, fPass, fWarn}));
    chk("R7 event flags", 32'({flagWord[15:11], flagWord[7:0]}),
        32'({fMbx, fAbort, 2'b00, fLost, 3'b000, 5'(mNum)}));
    chk("R8 flag upper bits", 32'(flagWord[31:16]), 32'd0);
    chk("R9 irqLine0", 32'(irqLine0), 32'(mLine[0] & ((sys & !mLine[2]) | (mb & !lv))));
    chk("R10 irqLine1", 32'(irqLine1), 32'(mLine[1] & ((sys & mLine[2]) | (mb & lv))));
  endtask

  task automatic clearIns();
    txErrEvt = 0; txOkEvt = 0; rxErrEvt = 0; rxOkEvt = 0; busErrCause = '0;
    rxLostEvt = 0; abortAckEvt = 0; mbxDoneEvt = 0; mbxNum = '0;
    reinitReq = 0; regWrEn = 0; regAddr = '0; regWData = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
    clearIns();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1; regAddr = a; regWData = d;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired (R11 run did not complete)");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    clearIns();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 status", statusWord, 32'd0);
    chk("R11 flags", flagWord, 32'd0);
    chk("R11 counts", {txErrCnt, rxErrCnt}, 32'd0);
    chk("R11 lines", {irqLine0, irqLine1, busOff}, 32'd0);
    compareAll();

    // R1 receive count up and floor at zero
    for (int i = 0; i < 3; i++) begin rxErrEvt = 1; tick(); end
    chk("R1 rec after 3", 32'(rxErrCnt), 32'd3);
    for (int i = 0; i < 5; i++) begin rxOkEvt = 1; tick(); end
    chk("R1 rec floor", 32'(rxErrCnt), 32'd0);

    // R1 error beats success in the same cycle
    txErrEvt = 1; txOkEvt = 1; tick();
    chk("R1 error wins", 32'(txErrCnt), 32'd8);

    // R2 / R6 warning entry
    for (int i = 0; i < 11; i++) begin txErrEvt = 1; tick(); end
    chk("R2 warn at 96", 32'(statusWord[16]), 32'd1);
    chk("R6 flag not yet", 32'(flagWord[8]), 32'd0);
    tick();
    chk("R6 warn flag", 32'(flagWord[8]), 32'd1);

    // R3 passive entry
    for (int i = 0; i < 4; i++) begin txErrEvt = 1; tick(); end
    chk("R3 passive at 128", 32'(statusWord[17]), 32'd1);
    tick();
    chk("R6 passive flag", 32'(flagWord[9]), 32'd1);

    // R8 clear all, R6 no re-raise while staying in state
    wr(2'd1, 32'hFFFF_FFFF);
    chk("R8 flags cleared", flagWord, 32'd0);
    txErrEvt = 1; tick();
    tick();
    chk("R6 no re-raise", 32'(flagWord[9:8]), 32'd0);

    // R9 enable and steering
    wr(2'd2, 32'h0000_FF01);
    rxLostEvt = 1; tick();
    chk("R7 lost flag", 32'(flagWord[11]), 32'd1);
    chk("R9 line0 up", {irqLine0, irqLine1}, 32'b10);
    wr(2'd2, 32'h0000_FF07);
    chk("R9 steered to line1", {irqLine0, irqLine1}, 32'b01);
    wr(2'd1, 32'h0000_0800);
    chk("R9 lines drop", {irqLine0, irqLine1}, 32'b00);

    // R10 per-mailbox level
    wr(2'd3, 32'h0000_0020);
    mbxDoneEvt = 1; mbxNum = 5'd5; tick();
    chk("R7 mailbox number", 32'(flagWord[4:0]), 32'd5);
    chk("R10 mbx 5 to line1", {irqLine0, irqLine1}, 32'b01);
    wr(2'd1, 32'h0000_801F);
    chk("R8 number kept", 32'(flagWord[15:0]), 32'h0005);
    mbxDoneEvt = 1; mbxNum = 5'd6; tick();
    chk("R10 mbx 6 to line0", {irqLine0, irqLine1}, 32'b10);
    abortAckEvt = 1; tick();
    chk("R7 abort flag", 32'(flagWord[14]), 32'd1);
    wr(2'd1, 32'hFFFF_FFFF);

    // R4 bus-off entry, freeze, exit
    for (int i = 0; i < 14; i++) begin txErrEvt = 1; tick(); end
    chk("R4 not yet off", 32'(busOff), 32'd0);
    txErrEvt = 1; tick();
    chk("R4 off above 255", {23'd0, busOff, txErrCnt}, 32'h300);
    txErrEvt = 1; rxErrEvt = 1; txOkEvt = 1; tick();
    chk("R4 frozen", {txErrCnt, rxErrCnt}, {15'd0, 9'h100, 8'd0});
    chk("R6 off flag", 32'(flagWord[10]), 32'd1);
    reinitReq = 1; tick();
    chk("R4 reinit", {23'd0, busOff, txErrCnt}, 32'd0);

    // R1 receive saturation, R3 from receive side
    for (int i = 0; i < 260; i++) begin rxErrEvt = 1; tick(); end
    chk("R1 rec saturates", 32'(rxErrCnt), 32'd255);
    chk("R3 passive from rec", 32'(statusWord[17]), 32'd1);
    reinitReq = 1; tick();

    // R5 causes
    busErrCause = 6'b000101; tick();
    chk("R5 ack and crc", 32'(statusWord[24:19]), 32'b000101);
    busErrCause = 6'b000001; regWrEn = 1; regAddr = 2'd0; regWData = 32'h0008_0000; tick();
    chk("R5 set wins", 32'(statusWord[24:19]), 32'b000101);
    wr(2'd0, 32'h0020_0000);
    chk("R5 crc cleared", 32'(statusWord[24:19]), 32'b000001);
    wr(2'd0, 32'h0009_0000);
    chk("R5 all cleared", statusWord, 32'd0);

    // R8 set wins over clear
    rxLostEvt = 1; regWrEn = 1; regAddr = 2'd1; regWData = 32'h0000_0800; tick();
    chk("R8 set wins", 32'(flagWord[11]), 32'd1);

    // mixed stimulus compared every cycle
    for (int n = 0; n < 4000; n++) begin
      txErrEvt    = ($urandom % 5) == 0;
      txOkEvt     = ($urandom % 3) == 0;
      rxErrEvt    = ($urandom % 3) == 0;
      rxOkEvt     = ($urandom % 4) == 0;
      busErrCause = (($urandom % 6) == 0) ? 6'($urandom) : 6'd0;
      rxLostEvt   = ($urandom % 40) == 0;
      abortAckEvt = ($urandom % 40) == 0;
      mbxDoneEvt  = ($urandom % 10) == 0;
      mbxNum      = 5'($urandom);
      reinitReq   = ($urandom % 300) == 0;
      regWrEn     = ($urandom % 8) == 0;
      regAddr     = 2'($urandom);
      regWData    = $urandom;
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule